// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides when an external successive-approximation converter begins a conversion and which of its five analog inputs that conversion samples. Software writes one control word, through a single write strobe with separate field inputs, that holds a master enable, a continuous-run bit, a single-shot request, a 3-bit channel select, a 5-bit rotation mask and a write-one-to-clear bit for the sticky error. The block issues a one-cycle start pulse together with the channel number. It then waits for the converter's done strobe, which carries a 12-bit sample and an error flag.

When the rotation mask is zero, every conversion samples the fixed channel select. When the mask has any bit set, the first conversion samples the channel the select already holds. Each completed conversion then moves the select to the next channel enabled in the mask, so a continuous run walks the enabled inputs in a loop without software taking part. The block reports whether a new conversion may begin, the latest sample, an error flag for the latest conversion and a sticky error that collects all of them.

Top module: `conv_seq`

## Requirements
- R1: After reset, every control field reads 0 (enable, continuous, single-shot pending, select, mask), ready reads 1, the sample and both error flags read 0, and the start pulse is low.
- R2: No start pulse is issued while the enable field is 0, whatever the other fields hold.
- R3: A write with the single-shot bit 1 and the continuous bit 0 sets the pending flag. The start pulse is asserted, for exactly one cycle, in the first cycle in which enable is 1, ready is 1 and a request is pending. The pending flag reads 0 from the next cycle unless a write lands in that same cycle.
- R4: A single-shot bit written together with a continuous bit of 1 is dropped, and the pending flag reads 0 after that write.
- R5: While continuous and enable are both 1, the next start pulse is asserted in the cycle right after the clock edge that accepts the done strobe.
- R6: Ready reads 0 from the cycle after a start pulse until the edge that accepts a done strobe. A done strobe that arrives while ready is 1 has no effect on the sample, the error flags or the select.
- R7: The 12-bit sample register loads the converter data on the edge that accepts a done strobe and holds it until the next accepted strobe.
- R8: The current error flag takes the error input of the latest accepted done strobe. The sticky flag sets on any accepted done strobe with the error input high. A write with the clear bit 1 resets the sticky flag, but an error accepted on the same edge keeps it set.
- R9: With the mask all zero, the select field keeps its value across conversions.
- R10: With a nonzero mask, the edge that accepts a done strobe loads the select with the channel (select + k) mod 5 for the smallest k in 1..5 whose mask bit (bit n is channel n) is set. A channel that is the only one enabled is therefore chosen again, and select values 5 to 7 wrap the same way.
- R11: The channel output equals the select field. A control write on the same edge as an accepted done strobe takes priority over the automatic advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Control word write strobe |
| wr_en | input | 1 | Master enable value |
| wr_cont | input | 1 | Continuous-run value |
| wr_once | input | 1 | Single-shot request |
| wr_sel | input | 3 | Channel select value |
| wr_mask | input | 5 | Rotation mask value, bit n enables channel n |
| wr_err_clr | input | 1 | Write 1 to clear the sticky error |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter sample |
| conv_err | input | 1 | Converter error flag for this sample |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel to sample |
| ctl_en | output | 1 | Enable field readback |
| ctl_cont | output | 1 | Continuous field readback |
| ctl_once | output | 1 | Single-shot pending readback |
| ctl_sel | output | 3 | Select field readback |
| ctl_mask | output | 5 | Mask field readback |
| ready | output | 1 | 1 when no conversion is in flight |
| result | output | 12 | Latest sample |
| err_now | output | 1 | Error flag of the latest conversion |
| err_sticky | output | 1 | Accumulated error flag |

## Verification
The bench builds the block with its default parameters: five channels, a 3-bit select and a 12-bit sample. At this size every mask pattern and every select value, including the three out-of-range values, can be reached by pseudo-random control writes. The converter stand-in varies its latency between one and three cycles. Because of this, control writes regularly land on the same edge as a done strobe or a start pulse, which exposes the write-over-advance and set-over-clear priorities. An idle done strobe and a pending single-shot held back by a zero enable are each driven on purpose.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } phase_t;

  function automatic int unsigned sel_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/conv_seq_rst_sync.sv
module conv_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/conv_seq_rr_pick.sv
module conv_seq_rr_pick #(
  parameter int unsigned NCH   = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] cur_sel,
  input  logic [NCH-1:0]   mask,
  output logic [SEL_W-1:0] nxt_sel,
  output logic             any_set
);

  // Scan from the farthest candidate down to the nearest one so the
  // nearest enabled channel is the last value written.
  always_comb begin
    nxt_sel = cur_sel;
    for (int k = NCH; k >= 1; k--) begin
      int idx;
      idx = (int'(cur_sel) + k) % int'(NCH);
      if (mask[idx]) begin
        nxt_sel = SEL_W'(idx);
      end
    end
  end

  assign any_set = |mask;

endmodule

// File: rtl/conv_seq_ctl_regs.sv
module conv_seq_ctl_regs #(
  parameter int unsigned NCH   = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             wr_en,
  input  logic             wr_cont,
  input  logic             wr_once,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NCH-1:0]   wr_mask,
  input  logic             launch,
  input  logic             adv_valid,
  input  logic [SEL_W-1:0] adv_sel,
  output logic             en_q,
  output logic             cont_q,
  output logic             once_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [NCH-1:0]   mask_q
);

  logic             en_d, cont_d, once_d;
  logic [SEL_W-1:0] sel_d;
  logic [NCH-1:0]   mask_d;

  always_comb begin
    en_d   = en_q;
    cont_d = cont_q;
    mask_d = mask_q;
    once_d = once_q & ~launch;
    sel_d  = adv_valid ? adv_sel : sel_q;
    if (cfg_wr) begin
      en_d   = wr_en;
      cont_d = wr_cont;
      mask_d = wr_mask;
      sel_d  = wr_sel;
      once_d = wr_once & ~wr_cont;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      once_q <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      cont_q <= cont_d;
      once_q <= once_d;
      sel_q  <= sel_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/conv_seq_engine.sv
module conv_seq_engine
  import conv_seq_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             cont_q,
  input  logic             once_q,
  input  logic             mask_any,
  input  logic             err_clr,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             conv_err,
  output logic             launch,
  output logic             adv_valid,
  output logic             ready,
  output logic [RES_W-1:0] result,
  output logic             err_now,
  output logic             err_sticky
);

  phase_t           phase_q, phase_d;
  logic             accept;
  logic             sticky_d;
  logic [RES_W-1:0] result_q;
  logic             err_now_q, sticky_q;

  assign launch    = en_q & (phase_q == PH_IDLE) & (cont_q | once_q);
  assign accept    = conv_done & (phase_q == PH_BUSY);
  assign adv_valid = accept & mask_any;

  always_comb begin
    phase_d = phase_q;
    if (launch) begin
      phase_d = PH_BUSY;
    end else if (accept) begin
      phase_d = PH_IDLE;
    end
    sticky_d = (sticky_q & ~err_clr) | (accept & conv_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      sticky_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      sticky_q <= sticky_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q  <= '0;
      err_now_q <= 1'b0;
    end else if (accept) begin
      result_q  <= conv_data;
      err_now_q <= conv_err;
    end
  end

  assign ready      = (phase_q == PH_IDLE);
  assign result     = result_q;
  assign err_now    = err_now_q;
  assign err_sticky = sticky_q;

endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int unsigned NCH   = 5,
  parameter int unsigned RES_W = 12,
  parameter int unsigned SEL_W = conv_seq_pkg::sel_bits(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             wr_en,
  input  logic             wr_cont,
  input  logic             wr_once,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NCH-1:0]   wr_mask,
  input  logic             wr_err_clr,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             conv_err,
  output logic             conv_start,
  output logic [SEL_W-1:0] conv_chan,
  output logic             ctl_en,
  output logic             ctl_cont,
  output logic             ctl_once,
  output logic [SEL_W-1:0] ctl_sel,
  output logic [NCH-1:0]   ctl_mask,
  output logic             ready,
  output logic [RES_W-1:0] result,
  output logic             err_now,
  output logic             err_sticky
);

  logic             rst_n_sync;
  logic             launch, adv_valid, mask_any;
  logic [SEL_W-1:0] adv_sel;

  conv_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  conv_seq_ctl_regs #(.NCH(NCH), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_wr    (cfg_wr),
    .wr_en     (wr_en),
    .wr_cont   (wr_cont),
    .wr_once   (wr_once),
    .wr_sel    (wr_sel),
    .wr_mask   (wr_mask),
    .launch    (launch),
    .adv_valid (adv_valid),
    .adv_sel   (adv_sel),
    .en_q      (ctl_en),
    .cont_q    (ctl_cont),
    .once_q    (ctl_once),
    .sel_q     (ctl_sel),
    .mask_q    (ctl_mask)
  );

  conv_seq_rr_pick #(.NCH(NCH), .SEL_W(SEL_W)) u_pick (
    .cur_sel (ctl_sel),
    .mask    (ctl_mask),
    .nxt_sel (adv_sel),
    .any_set (mask_any)
  );

  conv_seq_engine #(.RES_W(RES_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .en_q       (ctl_en),
    .cont_q     (ctl_cont),
    .once_q     (ctl_once),
    .mask_any   (mask_any),
    .err_clr    (cfg_wr & wr_err_clr),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .conv_err   (conv_err),
    .launch     (launch),
    .adv_valid  (adv_valid),
    .ready      (ready),
    .result     (result),
    .err_now    (err_now),
    .err_sticky (err_sticky)
  );

  assign conv_start = launch;
  assign conv_chan  = ctl_sel;

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int unsigned NCH   = 5,
  parameter int unsigned RES_W = 12,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             cfg_wr,
  input logic             wr_cont,
  input logic             ctl_en,
  input logic             ctl_once,
  input logic [SEL_W-1:0] ctl_sel,
  input logic [NCH-1:0]   ctl_mask,
  input logic             ready,
  input logic [RES_W-1:0] result,
  input logic             err_sticky,
  input logic             conv_start,
  input logic             conv_done,
  input logic             conv_err
);

  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ctl_en |-> !conv_start);

  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_start |=> !conv_start);

  a_r3_pending_consumed: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (conv_start && !cfg_wr) |=> !ctl_once);

  a_r4_once_dropped: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg_wr && wr_cont) |=> !ctl_once);

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_start |=> !ready);

  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (conv_done && !ready) |=> ready);

  a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(conv_done && !ready) |=> $stable(result));

  a_r8_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (conv_done && !ready && conv_err) |=> err_sticky);

  a_r9_select_fixed: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!cfg_wr && ctl_mask == '0) |=> $stable(ctl_sel));

endmodule

bind conv_seq conv_seq_chk #(.NCH(NCH), .RES_W(RES_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .cfg_wr     (cfg_wr),
  .wr_cont    (wr_cont),
  .ctl_en     (ctl_en),
  .ctl_once   (ctl_once),
  .ctl_sel    (ctl_sel),
  .ctl_mask   (ctl_mask),
  .ready      (ready),
  .result     (result),
  .err_sticky (err_sticky),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .conv_err   (conv_err)
);

// File: tb/conv_seq_test.sv
module conv_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, wr_en = 1'b0, wr_cont = 1'b0, wr_once = 1'b0, wr_err_clr = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [4:0]  wr_mask = '0;
  logic        conv_start, ctl_en, ctl_cont, ctl_once, ready, err_now, err_sticky;
  logic [2:0]  conv_chan, ctl_sel;
  logic [4:0]  ctl_mask;
  logic [11:0] result;

  // converter stand-in and idle strobe injector
  logic        cv_done = 1'b0, cv_err = 1'b0;
  logic [11:0] cv_data = '0;
  logic        spur = 1'b0;
  logic        conv_done, conv_err;
  logic [11:0] conv_data;
  assign conv_done = cv_done | spur;
  assign conv_data = spur ? 12'hABC : cv_data;
  assign conv_err  = spur ? 1'b1 : cv_err;

  always #10 clk = ~clk;

  conv_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wr_en(wr_en), .wr_cont(wr_cont),
    .wr_once(wr_once), .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_err_clr(wr_err_clr),
    .conv_done(conv_done), .conv_data(conv_data), .conv_err(conv_err),
    .conv_start(conv_start), .conv_chan(conv_chan), .ctl_en(ctl_en), .ctl_cont(ctl_cont),
    .ctl_once(ctl_once), .ctl_sel(ctl_sel), .ctl_mask(ctl_mask), .ready(ready),
    .result(result), .err_now(err_now), .err_sticky(err_sticky)
  );

  int vectors = 0, fails = 0, cyc = 0, seq = 0, cnt = 0, cur_chan = 0;
  bit finished = 0;

  // reference model state
  int m_en, m_cont, m_once, m_sel, m_mask, m_busy, m_res, m_errn, m_sticky;

  function automatic int next_chan(int s, int msk);
    for (int k = 1; k <= 5; k++) begin
      int c = (s + k) % 5;
      if (((msk >> c) & 1) == 1) return c;
    end
    return s;
  endfunction

  function automatic int m_launch();
    return (m_en == 1 && m_busy == 0 && (m_cont == 1 || m_once == 1)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_cont = 0; m_once = 0; m_sel = 0; m_mask = 0;
      m_busy = 0; m_res = 0; m_errn = 0; m_sticky = 0;
    end else begin
      int go, acc;
      go  = m_launch();
      acc = (conv_done && m_busy == 1) ? 1 : 0;
      if (acc == 1) begin
        m_res  = int'(conv_data);
        m_errn = int'(conv_err);
      end
      if (cfg_wr && wr_err_clr) m_sticky = 0;
      if (acc == 1 && conv_err) m_sticky = 1;
      if (cfg_wr) begin
        m_en = int'(wr_en); m_cont = int'(wr_cont); m_mask = int'(wr_mask);
        m_sel = int'(wr_sel); m_once = (wr_once && !wr_cont) ? 1 : 0;
      end else begin
        if (go == 1) m_once = 0;
        if (acc == 1 && m_mask != 0) m_sel = next_chan(m_sel, m_mask);
      end
      if (go == 1) m_busy = 1;
      else if (acc == 1) m_busy = 0;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // compare every cycle, then update the converter stand-in
  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (!rst_n) begin
      cmp("R1", "reset ready", int'(ready), 1);
      cmp("R1", "reset ctl_sel", int'(ctl_sel), 0);
      cmp("R1", "reset ctl_mask", int'(ctl_mask), 0);
      cmp("R1", "reset ctl_en", int'(ctl_en), 0);
      cmp("R1", "reset result", int'(result), 0);
      cmp("R1", "reset err_sticky", int'(err_sticky), 0);
      cmp("R1", "reset conv_start", int'(conv_start), 0);
    end
    cmp("R1", "ctl_en", int'(ctl_en), m_en);
    cmp("R1", "ctl_cont", int'(ctl_cont), m_cont);
    cmp("R1", "ctl_mask", int'(ctl_mask), m_mask);
    cmp("R2_R3_R5", "conv_start", int'(conv_start), m_launch());
    cmp("R3_R4", "ctl_once", int'(ctl_once), m_once);
    cmp("R6", "ready", int'(ready), 1 - m_busy);
    cmp("R7", "result", int'(result), m_res);
    cmp("R8", "err_now", int'(err_now), m_errn);
    cmp("R8", "err_sticky", int'(err_sticky), m_sticky);
    cmp("R9_R10", "ctl_sel", int'(ctl_sel), m_sel);
    cmp("R11", "conv_chan", int'(conv_chan), m_sel);

    cv_done = 1'b0;
    if (!rst_n) begin
      cnt = 0;
    end else begin
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          seq++;
          cv_done = 1'b1;
          cv_data = 12'((cur_chan * 256 + seq * 37) & 12'hFFF);
          cv_err  = ((seq % 4) == 3);
        end
      end
      if (conv_start) begin
        cur_chan = int'(conv_chan);
        cnt = 1 + (seq % 3);
      end
    end

    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic wr(input bit en, input bit cont, input bit once,
                    input int sel, input int msk, input bit clr);
    @(negedge clk);
    cfg_wr = 1'b1; wr_en = en; wr_cont = cont; wr_once = once;
    wr_sel = 3'(sel); wr_mask = 5'(msk); wr_err_clr = clr;
    @(negedge clk);
    cfg_wr = 1'b0; wr_once = 1'b0; wr_err_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R2: pending single-shot with enable 0 never starts
    wr(0, 0, 1, 2, 0, 0);
    idle(10);
    // R3 single conversion, R9 fixed select
    wr(1, 0, 1, 2, 0, 0);
    idle(8);
    // R4 single-shot dropped with continuous, R5 back-to-back
    wr(1, 1, 1, 2, 0, 0);
    idle(20);
    wr(1, 0, 0, m_sel, 0, 0);
    idle(8);
    // R10 rotation over channels 1,2,4
    wr(1, 1, 0, 0, 5'b10110, 0);
    idle(40);
    wr(1, 0, 0, m_sel, 5'b10110, 0);
    idle(8);
    // R10 single enabled channel repeats
    wr(1, 1, 0, 3, 5'b01000, 0);
    idle(15);
    wr(1, 0, 0, m_sel, 0, 0);
    idle(8);
    // R10 out-of-range select wraps
    wr(1, 0, 1, 6, 5'b00011, 0);
    idle(8);
    wr(1, 0, 1, m_sel, 5'b00011, 0);
    idle(8);
    // R8 sticky clear
    wr(1, 0, 0, m_sel, 0, 1);
    idle(3);
    // R6 idle done strobe ignored
    wr(0, 0, 0, 0, 0, 0);
    idle(3);
    @(negedge clk); spur = 1'b1;
    @(negedge clk); spur = 1'b0;
    idle(3);
    // mixed traffic: writes collide with starts and done strobes (R11, R8)
    lfsr = 32'h1D2C;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      idle(lfsr % 5);
      wr((lfsr & 7) != 0, ((lfsr >> 3) & 1) == 1, ((lfsr >> 4) & 1) == 1,
         (lfsr >> 5) & 7, (lfsr >> 8) & 31, ((lfsr >> 13) & 3) == 0);
    end
    wr(0, 0, 0, 0, 0, 0);
    idle(10);
    finish_run();
  end

endmodule